// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block gathers 63 level-sensitive interrupt request lines from peripherals and sorts them into seven interrupt levels. Within one level, a request with a larger priority value wins over one with a smaller value. A processor sees only a 3-bit code: the highest level that is pending and not masked. Software sets the level, the priority and an individual mask bit for each source through a small register write port.

When the processor acknowledges a level, the controller answers the acknowledge read by itself. It returns an 8-bit vector that identifies the winning source at that level. No peripheral is accessed during the acknowledge, and the acknowledge does not clear anything. A request stays pending until its source line drops. The processor's current mask level blocks that level and every lower one, except level 7.

Top module: `lpic_top`

## Requirements
- R1: After reset every source is masked and has level 0, `irqLevel` is 0 and `vector` is 0, whatever the request lines carry.
- R2: One clock after the inputs change, `irqLevel` shows the highest level that has an active source (line high, mask bit clear, level nonzero). It shows 0 when no source is active.
- R3: An active level-7 source is reported on `irqLevel` even when `cpuMask` is 7.
- R4: A source whose level field is 0, or whose mask bit is set, never contributes to `irqLevel` or to a vector.
- R5: Within one level, the active source with the numerically larger 4-bit priority wins the acknowledge.
- R6: When active sources share both a level and a priority, the lower-numbered source wins.
- R7: The vector for a winning source n is 64 + n, so it lies in 64..126. Vectors below 64 other than the spurious code are never produced.
- R8: An acknowledge for a level with no active source returns the spurious vector 24. An acknowledge for level 0 always returns 24.
- R9: The vector is captured at the first clock edge that sees `ackStrobe` high. It holds unchanged while the strobe stays high, even if requests change. It returns to 0 one clock after the strobe drops.
- R10: An acknowledge does not clear a request: `irqLevel` keeps reporting the level while the source line stays high.
- R11: Levels from 1 to 6 are reported only when they are greater than `cpuMask`. Raising the mask to the acknowledged level blocks that level and all lower ones.
- R12: A write with `cfgWrEn` high updates source `cfgAddr`. In `cfgData`, bits [3:0] hold the priority, bits [6:4] the level and bit 7 the mask. Writes to address 63 change no source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqLines | input | 63 | Level-sensitive request from each source |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgAddr | input | 6 | Source index for the write |
| cfgData | input | 8 | {mask, level[2:0], priority[3:0]} |
| cpuMask | input | 3 | Processor's current interrupt mask level |
| ackStrobe | input | 1 | Acknowledge read in progress |
| ackLevel | input | 3 | Level being acknowledged |
| irqLevel | output | 3 | Highest pending unmasked level, 0 for none |
| vector | output | 8 | Acknowledge vector, 0 while no acknowledge |

## Verification
Vector capture and request-level update can happen in the same cycle. The bench raises a new request line on the same clock as the acknowledge strobe for its level. It then expects the captured vector to already name that new source, and `irqLevel` to show the level on that same sample. A second overlap changes the request lines while the strobe is held. The vector must stay frozen while `irqLevel` tracks the new requests.

// File: rtl/lpic_pkg.sv
package lpic_pkg;
  localparam int NUM_SRC   = 63;
  localparam int NUM_LVL   = 7;
  localparam int LVL_W     = 3;
  localparam int PRI_W     = 4;
  localparam int IDX_W     = 6;
  localparam int VEC_W     = 8;
  localparam int CFG_W     = 1 + LVL_W + PRI_W;
  localparam int USER_BASE = 64;
  localparam int SPURIOUS  = 24;

  typedef struct packed {
    logic cfgWr;   // commit cfgData into the addressed source
    logic capVec;  // first cycle of an acknowledge: latch vector
    logic clrVec;  // no acknowledge: return vector to zero
  } ctrlStrobe_t;
endpackage

// File: rtl/lpic_ctrl.sv
module lpic_ctrl
  import lpic_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [IDX_W-1:0] cfgAddr,
  input  logic             ackStrobe,
  output ctrlStrobe_t      strobes
);
  logic ackPrev;

  always_ff @(posedge clk) begin
    if (!rstN) ackPrev <= 1'b0;
    else       ackPrev <= ackStrobe;
  end

  always_comb begin
    strobes.cfgWr  = cfgWrEn && (cfgAddr < IDX_W'(NUM_SRC));
    strobes.capVec = ackStrobe && !ackPrev;
    strobes.clrVec = !ackStrobe;
  end
endmodule

// File: rtl/lpic_datapath.sv
module lpic_datapath
  import lpic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobes,
  input  logic [IDX_W-1:0]   cfgAddr,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic [NUM_SRC-1:0] reqLines,
  input  logic [LVL_W-1:0]   cpuMask,
  input  logic [LVL_W-1:0]   ackLevel,
  output logic [LVL_W-1:0]   irqLevel,
  output logic [VEC_W-1:0]   vector
);
  logic [PRI_W-1:0]   srcPri [NUM_SRC];
  logic [LVL_W-1:0]   srcLvl [NUM_SRC];
  logic [NUM_SRC-1:0] srcMsk;
  logic [NUM_SRC-1:0] srcAct;

  logic [NUM_LVL:0]   anyAt;
  logic [IDX_W-1:0]   winIdx [NUM_LVL+1];
  logic [LVL_W-1:0]   pendLvl;
  logic [LVL_W-1:0]   irqNext;
  logic [VEC_W-1:0]   ackVec;

  // source configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        srcPri[i] <= '0;
        srcLvl[i] <= '0;
      end
      srcMsk <= '1;
    end else if (strobes.cfgWr) begin
      srcPri[cfgAddr] <= cfgData[PRI_W-1:0];
      srcLvl[cfgAddr] <= cfgData[PRI_W +: LVL_W];
      srcMsk[cfgAddr] <= cfgData[CFG_W-1];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      srcAct[i] = reqLines[i] && !srcMsk[i] && (srcLvl[i] != '0);
  end

  // tier two: pick the winner inside each level
  assign anyAt[0]  = 1'b0;
  assign winIdx[0] = '0;

  for (genvar g = 1; g <= NUM_LVL; g++) begin : g_lvl
    logic             hit;
    logic [PRI_W-1:0] bestPri;
    logic [IDX_W-1:0] bestIdx;

    always_comb begin
      hit     = 1'b0;
      bestPri = '0;
      bestIdx = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (srcAct[i] && srcLvl[i] == LVL_W'(g) && (!hit || srcPri[i] > bestPri)) begin
          hit     = 1'b1;
          bestPri = srcPri[i];
          bestIdx = IDX_W'(i);
        end
      end
    end

    assign anyAt[g]  = hit;
    assign winIdx[g] = bestIdx;
  end

  // tier one: highest pending level against the processor mask
  always_comb begin
    pendLvl = '0;
    for (int l = 1; l <= NUM_LVL; l++)
      if (anyAt[l]) pendLvl = LVL_W'(l);
    if (pendLvl > cpuMask || pendLvl == LVL_W'(NUM_LVL)) irqNext = pendLvl;
    else                                                  irqNext = '0;
  end

  always_comb begin
    if (anyAt[ackLevel]) ackVec = VEC_W'(USER_BASE) + VEC_W'(winIdx[ackLevel]);
    else                 ackVec = VEC_W'(SPURIOUS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqLevel <= '0;
      vector   <= '0;
    end else begin
      irqLevel <= irqNext;
      if (strobes.capVec)      vector <= ackVec;
      else if (strobes.clrVec) vector <= '0;
    end
  end
endmodule

// File: rtl/lpic_top.sv
module lpic_top
  import lpic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqLines,
  input  logic               cfgWrEn,
  input  logic [IDX_W-1:0]   cfgAddr,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic [LVL_W-1:0]   cpuMask,
  input  logic               ackStrobe,
  input  logic [LVL_W-1:0]   ackLevel,
  output logic [LVL_W-1:0]   irqLevel,
  output logic [VEC_W-1:0]   vector
);
  ctrlStrobe_t strobes;

  lpic_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .ackStrobe (ackStrobe),
    .strobes   (strobes)
  );

  lpic_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .reqLines (reqLines),
    .cpuMask  (cpuMask),
    .ackLevel (ackLevel),
    .irqLevel (irqLevel),
    .vector   (vector)
  );
endmodule

// File: rtl/lpic_checker.sv
module lpic_checker
  import lpic_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [LVL_W-1:0] cpuMask,
  input logic             ackStrobe,
  input logic [LVL_W-1:0] irqLevel,
  input logic [VEC_W-1:0] vector
);
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    vector == '0 || vector == VEC_W'(SPURIOUS) ||
    (vector >= VEC_W'(USER_BASE) && vector <= VEC_W'(USER_BASE + NUM_SRC - 1))); // R7

  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe && $past(ackStrobe) |=> $stable(vector)); // R9

  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ackStrobe |=> vector == '0); // R9

  AST_VEC_ANSWER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackStrobe) |=> vector != '0); // R8

  AST_IRQ_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rstN)
    irqLevel != '0 |-> (irqLevel > $past(cpuMask) || irqLevel == LVL_W'(NUM_LVL))); // R11
endmodule

bind lpic_top lpic_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuMask   (cpuMask),
  .ackStrobe (ackStrobe),
  .irqLevel  (irqLevel),
  .vector    (vector)
);

// File: tb/lpic_top_tb.sv
module lpic_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [62:0] reqLines = '0;
  logic        cfgWrEn = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [7:0]  cfgData = '0;
  logic [2:0]  cpuMask = '0;
  logic        ackStrobe = 1'b0;
  logic [2:0]  ackLevel = '0;
  logic [2:0]  irqLevel;
  logic [7:0]  vector;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lpic_top u_dut (
    .clk(clk), .rstN(rstN), .reqLines(reqLines), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .cpuMask(cpuMask),
    .ackStrobe(ackStrobe), .ackLevel(ackLevel),
    .irqLevel(irqLevel), .vector(vector)
  );

  localparam logic [62:0] S0  = 63'd1;
  localparam logic [62:0] S1  = 63'd1 << 1;
  localparam logic [62:0] S3  = 63'd1 << 3;
  localparam logic [62:0] S10 = 63'd1 << 10;
  localparam logic [62:0] S20 = 63'd1 << 20;
  localparam logic [62:0] S40 = 63'd1 << 40;
  localparam logic [62:0] S62 = 63'd1 << 62;

  localparam int NV = 10;
  localparam logic [62:0] TV_REQ  [NV] = '{63'd0, S3, S3|S40, S40, S40, S62, S0, S1, S3|S62, S3};
  localparam logic [2:0]  TV_MASK [NV] = '{3'd0, 3'd0, 3'd0, 3'd5, 3'd4, 3'd7, 3'd0, 3'd0, 3'd0, 3'd2};
  localparam logic [2:0]  TV_EXP  [NV] = '{3'd0, 3'd2, 3'd5, 3'd0, 3'd5, 3'd7, 3'd0, 3'd0, 3'd7, 3'd0};
  localparam string       TV_TAG  [NV] = '{"R2", "R2", "R2", "R11", "R11", "R3", "R4", "R4", "R3", "R11"};

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input bit msk, input int lvl, input int pri);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgAddr = 6'(idx);
    cfgData = {msk, 3'(lvl), 4'(pri)};
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic ackStart(input int lvl);
    ackStrobe = 1'b1;
    ackLevel  = 3'(lvl);
    @(negedge clk);
  endtask

  task automatic ackEnd();
    ackStrobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    reqLines = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", irqLevel, 0);
    check("R1 vector after reset", vector, 0);
    ackStart(7);
    check("R1 masked sources give spurious", vector, 24);
    ackEnd();
    check("R9 vector cleared", vector, 0);
    reqLines = '0;

    wr(3, 0, 2, 5);
    wr(10, 0, 2, 8);
    wr(20, 0, 2, 8);
    wr(40, 0, 5, 1);
    wr(62, 0, 7, 0);
    wr(0, 0, 0, 9);
    wr(1, 1, 6, 3);
    wr(63, 0, 1, 15);  // R12: address 63 must not alias a source

    for (int k = 0; k < NV; k++) begin
      reqLines = TV_REQ[k];
      cpuMask  = TV_MASK[k];
      @(negedge clk);
      check(TV_TAG[k], irqLevel, TV_EXP[k]);
    end

    cpuMask = 0;
    reqLines = S3 | S10 | S20;
    @(negedge clk);
    ackStart(2);
    check("R6 tie goes to source 10", vector, 74);
    ackEnd();
    reqLines = S3 | S20;
    @(negedge clk);
    ackStart(2);
    check("R5 higher priority wins", vector, 84);
    reqLines = S3;                // change requests while strobe is held
    @(negedge clk);
    @(negedge clk);
    check("R9 vector held under change", vector, 84);
    check("R10 request survives ack", irqLevel, 2);
    ackEnd();
    check("R9 vector released", vector, 0);
    ackStart(2);
    check("R7 vector 64 plus index", vector, 67);
    ackEnd();
    ackStart(4);
    check("R8 empty level spurious", vector, 24);
    ackEnd();
    ackStart(0);
    check("R8 level zero spurious", vector, 24);
    ackEnd();

    cpuMask = 2;                  // processor raised mask to acknowledged level
    @(negedge clk);
    check("R11 acked level blocked", irqLevel, 0);
    cpuMask = 1;
    @(negedge clk);
    check("R11 lowered mask reopens", irqLevel, 2);
    cpuMask = 0;

    reqLines = S3 | S40;          // new request in the same cycle as ack
    ackStart(5);
    check("R7 same-cycle request vector", vector, 104);
    check("R2 same-cycle irq", irqLevel, 5);
    ackEnd();

    reqLines = S62;
    @(negedge clk);
    ackStart(7);
    check("R12 source 62 intact", vector, 126);
    ackEnd();
    reqLines = '0;
    @(negedge clk);
    check("R12 address 63 created no source", irqLevel, 0);

    wr(62, 1, 7, 0);              // R12 mask bit via write
    reqLines = S62;
    @(negedge clk);
    check("R12 mask bit blocks source", irqLevel, 0);
    wr(1, 0, 6, 3);
    reqLines = S1;
    @(negedge clk);
    check("R12 unmask and level applied", irqLevel, 6);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule